// File: doc/BRIEF.md
# Banked Interrupt Selector

This block looks at one bank of per-processor interrupt sources and decides which of them may be signalled. Each source carries a pending latch, a trigger-mode bit, a live line input, an enable bit, a group bit, a group-modifier bit and a priority value. Four global controls also take part: three group enables and one bit that switches the security split off. A source is a candidate only if it is pending, enabled and its group is open.

Among the candidates the block picks the most urgent one and reports its number, its priority and a 2-bit group code. The result sits in a register, so it appears one clock after the inputs that produced it. The surrounding logic keeps all the source state. This block only qualifies and selects, and it holds nothing apart from the result register.

Top module: `irq_bank_arbiter`

## Requirements
- R1: A source is pending when its latch bit is 1, or when its trigger-mode bit is 0 (level-sensitive) and its line input is 1. A high line on a source whose trigger-mode bit is 1 (edge) does not make it pending.
- R2: A pending source whose enable bit is 0 is never reported.
- R3: While `sec_off` is 1, every group-modifier bit is treated as 0.
- R4: A source with group bit 1 passes only when `en_g1ns` is 1. A source with group bit 0 and effective modifier 1 passes only when `en_g1s` is 1. A source with group bit 0 and effective modifier 0 passes only when `en_g0` is 1.
- R5: Among the candidates, the one with the numerically smallest priority value is reported.
- R6: When several candidates share the smallest priority value, the one with the lowest index is reported.
- R7: A source whose priority is 0xFF is never reported. When no source qualifies, the outputs are `win_valid`=0, `win_id`=0, `win_prio`=0xFF and `win_grp`=0.
- R8: `win_grp` is 0 for group bit 0 with effective modifier 0, 1 for group bit 0 with effective modifier 1, and 2 for group bit 1. It never takes the value 3.
- R9: The outputs change only at a rising clock edge and reflect the inputs sampled at that edge. While `rst_n` is 0, the outputs hold the idle values of R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_latch | input | NUM_IRQ | Pending latch per source |
| trig_edge | input | NUM_IRQ | 1 = edge-triggered, 0 = level-sensitive |
| line_in | input | NUM_IRQ | Live line level per source |
| enable | input | NUM_IRQ | Per-source enable |
| grp_bit | input | NUM_IRQ | Group bit per source |
| grp_mod | input | NUM_IRQ | Group-modifier bit per source |
| prio_flat | input | NUM_IRQ*PRIO_W | Priorities; source i occupies bits [i*PRIO_W +: PRIO_W] |
| en_g0 | input | 1 | Opens group code 0 |
| en_g1s | input | 1 | Opens group code 1 |
| en_g1ns | input | 1 | Opens group code 2 |
| sec_off | input | 1 | Forces all modifiers to 0 |
| win_valid | output | 1 | A source was selected |
| win_id | output | ID_W | Index of the selected source |
| win_prio | output | PRIO_W | Priority of the selected source |
| win_grp | output | 2 | Group code of the selected source |

## Verification
The bench checks priority ties between sources that sit in different halves of the selection tree. A design that broke ties the wrong way would report the higher index. It makes an edge-mode source with a high line and no latch the only one present. A design that ignored the trigger mode would report that source. It turns `sec_off` on while only the modifier-1 enable is open. A design that kept the modifier would go on reporting group 1. An eligible source at priority 0xFF must still leave the outputs idle, which catches a selector that treats 0xFF as an ordinary value.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;

    typedef enum logic [1:0] {
        GRP_CODE_SEC0  = 2'd0,
        GRP_CODE_SEC1  = 2'd1,
        GRP_CODE_NSEC1 = 2'd2
    } grp_code_e;

    // group code from group bit and effective modifier
    function automatic logic [1:0] grp_encode(input logic gbit, input logic mod_eff);
        if (gbit)         return GRP_CODE_NSEC1;
        else if (mod_eff) return GRP_CODE_SEC1;
        else              return GRP_CODE_SEC0;
    endfunction

endpackage

// File: rtl/irqsel_qualify.sv
module irqsel_qualify #(
    parameter int NUM_IRQ = 32
) (
    input  logic [NUM_IRQ-1:0]      pend_latch,
    input  logic [NUM_IRQ-1:0]      trig_edge,
    input  logic [NUM_IRQ-1:0]      line_in,
    input  logic [NUM_IRQ-1:0]      enable,
    input  logic [NUM_IRQ-1:0]      grp_bit,
    input  logic [NUM_IRQ-1:0]      grp_mod,
    input  logic                    en_g0,
    input  logic                    en_g1s,
    input  logic                    en_g1ns,
    input  logic                    sec_off,
    output logic [NUM_IRQ-1:0]      cand,
    output logic [NUM_IRQ-1:0][1:0] grp_code
);
    import irqsel_pkg::*;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
        logic pending_w;
        logic mod_eff_w;
        logic open_w;

        assign pending_w = pend_latch[i] | (~trig_edge[i] & line_in[i]);
        assign mod_eff_w = grp_mod[i] & ~sec_off;
        assign open_w    = grp_bit[i] ? en_g1ns : (mod_eff_w ? en_g1s : en_g0);
        assign cand[i]   = pending_w & enable[i] & open_w;
        assign grp_code[i] = grp_encode(grp_bit[i], mod_eff_w);
    end

endmodule

// File: rtl/irqsel_pick.sv
module irqsel_pick #(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 8,
    parameter int ID_W    = 5
) (
    input  logic [NUM_IRQ-1:0]             cand,
    input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio,
    input  logic [NUM_IRQ-1:0][1:0]        grp_code,
    output logic                           found,
    output logic [ID_W-1:0]                best_id,
    output logic [PRIO_W-1:0]              best_prio,
    output logic [1:0]                     best_grp
);
    localparam int LEAVES = 1 << ID_W;

    logic              nv [LEAVES];
    logic [ID_W-1:0]   nid[LEAVES];
    logic [PRIO_W-1:0] np [LEAVES];
    logic [1:0]        ng [LEAVES];

    // pairwise tournament, lower index on the left keeps ties
    always_comb begin
        for (int k = 0; k < LEAVES; k++) begin
            if (k < NUM_IRQ) begin
                nv[k] = cand[k] && (prio[k] != {PRIO_W{1'b1}});
                np[k] = prio[k];
                ng[k] = grp_code[k];
            end else begin
                nv[k] = 1'b0;
                np[k] = {PRIO_W{1'b1}};
                ng[k] = 2'd0;
            end
            nid[k] = ID_W'(k);
        end
        for (int w = LEAVES / 2; w >= 1; w = w / 2) begin
            for (int k = 0; k < w; k++) begin
                if (nv[2*k] && (!nv[2*k+1] || np[2*k] <= np[2*k+1])) begin
                    nv[k]  = 1'b1;
                    nid[k] = nid[2*k];
                    np[k]  = np[2*k];
                    ng[k]  = ng[2*k];
                end else begin
                    nv[k]  = nv[2*k+1];
                    nid[k] = nid[2*k+1];
                    np[k]  = np[2*k+1];
                    ng[k]  = ng[2*k+1];
                end
            end
        end
        found     = nv[0];
        best_id   = nid[0];
        best_prio = np[0];
        best_grp  = ng[0];
    end

endmodule

// File: rtl/irq_bank_arbiter.sv
module irq_bank_arbiter #(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 8,
    parameter int ID_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IRQ-1:0]        pend_latch,
    input  logic [NUM_IRQ-1:0]        trig_edge,
    input  logic [NUM_IRQ-1:0]        line_in,
    input  logic [NUM_IRQ-1:0]        enable,
    input  logic [NUM_IRQ-1:0]        grp_bit,
    input  logic [NUM_IRQ-1:0]        grp_mod,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    input  logic                      en_g0,
    input  logic                      en_g1s,
    input  logic                      en_g1ns,
    input  logic                      sec_off,
    output logic                      win_valid,
    output logic [ID_W-1:0]           win_id,
    output logic [PRIO_W-1:0]         win_prio,
    output logic [1:0]                win_grp
);
    localparam logic [PRIO_W-1:0] PRIO_IDLE = {PRIO_W{1'b1}};

    typedef struct packed {
        logic              valid;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
        logic [1:0]        grp;
    } sel_t;

    localparam sel_t SEL_IDLE = '{valid: 1'b0, id: '0, prio: PRIO_IDLE, grp: 2'd0};

    logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_w;
    logic [NUM_IRQ-1:0]             cand_w;
    logic [NUM_IRQ-1:0][1:0]        grp_w;
    logic                           found_w;
    logic [ID_W-1:0]                bid_w;
    logic [PRIO_W-1:0]              bprio_w;
    logic [1:0]                     bgrp_w;
    sel_t                           sel_d, sel_q;

    assign prio_w = prio_flat;

    irqsel_qualify #(.NUM_IRQ(NUM_IRQ)) u_qual (
        .pend_latch (pend_latch),
        .trig_edge  (trig_edge),
        .line_in    (line_in),
        .enable     (enable),
        .grp_bit    (grp_bit),
        .grp_mod    (grp_mod),
        .en_g0      (en_g0),
        .en_g1s     (en_g1s),
        .en_g1ns    (en_g1ns),
        .sec_off    (sec_off),
        .cand       (cand_w),
        .grp_code   (grp_w)
    );

    irqsel_pick #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
        .cand      (cand_w),
        .prio      (prio_w),
        .grp_code  (grp_w),
        .found     (found_w),
        .best_id   (bid_w),
        .best_prio (bprio_w),
        .best_grp  (bgrp_w)
    );

    always_comb begin
        sel_d = SEL_IDLE;
        if (found_w) begin
            sel_d.valid = 1'b1;
            sel_d.id    = bid_w;
            sel_d.prio  = bprio_w;
            sel_d.grp   = bgrp_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= SEL_IDLE;
        else        sel_q <= sel_d;
    end

    assign win_valid = sel_q.valid;
    assign win_id    = sel_q.id;
    assign win_prio  = sel_q.prio;
    assign win_grp   = sel_q.grp;

endmodule

// File: rtl/irqsel_checker.sv
module irqsel_checker #(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 8,
    parameter int ID_W    = 5
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_IRQ-1:0]        enable,
    input logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    input logic                      en_g0,
    input logic                      en_g1s,
    input logic                      en_g1ns,
    input logic                      sec_off,
    input logic                      win_valid,
    input logic [ID_W-1:0]           win_id,
    input logic [PRIO_W-1:0]         win_prio,
    input logic [1:0]                win_grp
);
    logic                      seen_q;
    logic [NUM_IRQ-1:0]        en_s;
    logic [NUM_IRQ*PRIO_W-1:0] prio_s;
    logic [PRIO_W-1:0]         prio_of_win;

    always_ff @(posedge clk) begin
        seen_q <= rst_n;
        en_s   <= enable;
        prio_s <= prio_flat;
    end

    assign prio_of_win = PRIO_W'(prio_s >> (int'(win_id) * PRIO_W));

    p_idle_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |-> (win_prio == {PRIO_W{1'b1}} && win_id == '0 && win_grp == 2'd0));

    p_grp_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_grp != 2'd3);

    p_win_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && win_valid) |-> en_s[win_id]);

    p_win_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && win_valid) |-> (win_prio == prio_of_win && win_prio != {PRIO_W{1'b1}}));

    p_secoff_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && win_valid && $past(sec_off)) |-> win_grp != 2'd1);

    p_g0_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && win_valid && win_grp == 2'd0) |-> $past(en_g0));

    p_g1s_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && win_valid && win_grp == 2'd1) |-> $past(en_g1s));

    p_g1ns_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && win_valid && win_grp == 2'd2) |-> $past(en_g1ns));

endmodule

bind irq_bank_arbiter irqsel_checker #(
    .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .prio_flat (prio_flat),
    .en_g0     (en_g0),
    .en_g1s    (en_g1s),
    .en_g1ns   (en_g1ns),
    .sec_off   (sec_off),
    .win_valid (win_valid),
    .win_id    (win_id),
    .win_prio  (win_prio),
    .win_grp   (win_grp)
);

// File: tb/irq_bank_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_bank_arbiter_tb_top;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] pl, te, li, en, gb, gm;
    logic [7:0]  pr [N];
    logic [N*8-1:0] prio_flat;
    logic        e0, e1s, e1ns, so;
    logic        win_valid;
    logic [4:0]  win_id;
    logic [7:0]  win_prio;
    logic [1:0]  win_grp;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2.5 clk = ~clk;

    always_comb for (int i = 0; i < N; i++) prio_flat[i*8 +: 8] = pr[i];

    irq_bank_arbiter #(.NUM_IRQ(N), .PRIO_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .pend_latch(pl), .trig_edge(te), .line_in(li),
        .enable(en), .grp_bit(gb), .grp_mod(gm), .prio_flat(prio_flat),
        .en_g0(e0), .en_g1s(e1s), .en_g1ns(e1ns), .sec_off(so),
        .win_valid(win_valid), .win_id(win_id), .win_prio(win_prio), .win_grp(win_grp)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic void ref_pick(output logic v, output logic [4:0] id,
                                     output logic [7:0] p, output logic [1:0] g);
        v = 0; id = 0; p = 8'hFF; g = 0;
        for (int i = 0; i < N; i++) begin
            logic pend, mod, ok;
            logic [1:0] gc;
            pend = pl[i] | (~te[i] & li[i]);
            mod  = gm[i] & ~so;
            gc   = gb[i] ? 2'd2 : (mod ? 2'd1 : 2'd0);
            ok   = gb[i] ? e1ns : (mod ? e1s : e0);
            if (pend && en[i] && ok && pr[i] != 8'hFF && (!v || pr[i] < p)) begin
                v = 1; id = 5'(i); p = pr[i]; g = gc;
            end
        end
    endfunction

    task automatic clear_all();
        pl = '0; te = '0; li = '0; en = '0; gb = '0; gm = '0;
        e0 = 1; e1s = 1; e1ns = 1; so = 0;
        for (int i = 0; i < N; i++) pr[i] = 8'h80;
    endtask

    // inputs are set before the call at a negedge; result checked one edge later
    task automatic step_check(string tag);
        logic v; logic [4:0] id; logic [7:0] p; logic [1:0] g;
        ref_pick(v, id, p, g);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " valid"}, 32'(win_valid), 32'(v));
        chk({tag, " id"},    32'(win_id),    32'(id));
        chk({tag, " prio"},  32'(win_prio),  32'(p));
        chk({tag, " grp"},   32'(win_grp),   32'(g));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog got=hung exp=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        clear_all();
        pl = '1; en = '1; gb = '1;
        repeat (3) @(negedge clk);
        // R9: idle while reset is held even with eligible sources
        chk("R9 reset valid", 32'(win_valid), 0);
        chk("R9 reset prio",  32'(win_prio), 32'hFF);
        rst_n = 1'b1;
        clear_all();
        step_check("R7 empty");

        // R1: latch alone, non-secure group
        clear_all(); pl[5] = 1; en[5] = 1; gb[5] = 1; pr[5] = 8'd10;
        step_check("R1 latch");
        chk("R8 code2", 32'(win_grp), 2);
        // R1: level-sensitive line
        clear_all(); li[7] = 1; en[7] = 1; pr[7] = 8'd3;
        step_check("R1 level");
        chk("R1 level valid", 32'(win_valid), 1);
        // R1: edge mode ignores the line
        te[7] = 1;
        step_check("R1 edge line");
        chk("R1 edge idle", 32'(win_valid), 0);
        // R2: enable off
        clear_all(); pl[11] = 1; pr[11] = 8'd1;
        step_check("R2 disabled");
        chk("R2 idle", 32'(win_valid), 0);
        // R6: tie across halves
        clear_all(); pl[9] = 1; pl[3] = 1; pl[25] = 1; en = '1;
        pr[9] = 4; pr[3] = 4; pr[25] = 4;
        step_check("R6 tie");
        chk("R6 lowest id", 32'(win_id), 3);
        // R5: smaller value wins regardless of index
        pr[25] = 2;
        step_check("R5 lower value");
        chk("R5 id", 32'(win_id), 25);
        // R3/R4/R8: modifier handling
        clear_all(); pl[4] = 1; en[4] = 1; gm[4] = 1; pr[4] = 8'd6;
        e0 = 0; e1ns = 0;
        step_check("R4 g1s open");
        chk("R8 code1", 32'(win_grp), 1);
        so = 1;
        step_check("R3 secoff closed");
        chk("R3 idle", 32'(win_valid), 0);
        e0 = 1;
        step_check("R3 secoff as g0");
        chk("R3 code0", 32'(win_grp), 0);
        so = 0; e1s = 0;
        step_check("R4 g1s shut");
        // R4: non-secure group gated by its own enable only
        clear_all(); pl[30] = 1; en[30] = 1; gb[30] = 1; gm[30] = 1; e1ns = 0;
        step_check("R4 g1ns shut");
        // R7: eligible but priority 0xFF
        clear_all(); pl[0] = 1; en[0] = 1; pr[0] = 8'hFF;
        step_check("R7 prio ff");
        chk("R7 ff idle", 32'(win_valid), 0);
        // R9: output holds until the next edge
        clear_all(); pl[12] = 1; en[12] = 1; pr[12] = 8'd9;
        step_check("R9 setup");
        pl[12] = 0; pl[13] = 1; en[13] = 1; pr[13] = 8'd1;
        #1;
        chk("R9 held before edge", 32'(win_id), 12);
        step_check("R9 after edge");

        // random mix, narrow priority range to force ties
        for (int it = 0; it < 600; it++) begin
            pl = N'($urandom) & N'($urandom);
            te = N'($urandom); li = N'($urandom);
            en = N'($urandom) | N'($urandom);
            gb = N'($urandom); gm = N'($urandom);
            e0 = 1'($urandom); e1s = 1'($urandom); e1ns = 1'($urandom);
            so = ($urandom_range(0, 3) == 0);
            for (int i = 0; i < N; i++)
                pr[i] = ($urandom_range(0, 7) == 0) ? 8'hFF :
                        (($urandom_range(0, 1) == 1) ? 8'($urandom_range(0, 3)) : 8'($urandom));
            step_check("R5 R6 random");
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule